// File: doc/BRIEF.md
# Self-Checking Latin-Square Parity Encoder

This block is a purely combinational encoder for a single-error-correcting code built on two orthogonal Latin squares. It arranges the data word as an M by M grid (M = 4 by default, so 16 data bits). It produces 2M check bits: one even-parity bit per grid row, then one per grid column. A memory or cache write path places it in front of storage so that the check bits are stored beside the data word.

The encoder also watches its own logic. Every check bit is built from its own chain of M-1 two-input XOR gates, and no gate is shared between chains. Because each data bit feeds exactly two check bits, a fault-free encoder always produces check bits whose XOR is zero. The parity of the row checks and the parity of the column checks come out as a two-rail pair. An error flag rises when the two rails disagree.

A test override can force any one internal gate output to a chosen value. This models a single stuck-at node, and the flag should catch it.

Top module: `ols_sc_encoder`

## Requirements
- R1: For row index r in 0..M-1, check_out[r] is the XOR of data_in[r*M] through data_in[r*M+M-1].
- R2: For column index j in 0..M-1, check_out[M+j] is the XOR of data_in[j], data_in[j+M], data_in[j+2M] and so on up to data_in[j+(M-1)*M].
- R3: A data word with a single bit set yields exactly two set check bits, one row check and one column check. Two different single-bit words never share both of their set check bits.
- R4: With flt_en low, enc_err is 0 and rail_a equals rail_b for every data word.
- R5: rail_a is the XOR of check_out[M-1:0] and rail_b is the XOR of check_out[2M-1:M]. enc_err is 1 exactly when rail_a differs from rail_b.
- R6: With flt_en high and flt_sel = c*(M-1)+g below 2M(M-1), gate g of check c is forced to flt_val. Member i of check c is data_in[c*M+i] for a row check and data_in[(c-M)+i*M] for a column check. Gate 0 XORs members 0 and 1, and gate g XORs gate g-1 with member g+1. Only check_out[c] may change.
- R7: Under a valid forced node, check_out[c] inverts and enc_err is 1 exactly when flt_val differs from the fault-free value of that gate. Otherwise every output matches the fault-free result.
- R8: A flt_sel value of 2M(M-1) or above has no effect on any output, even with flt_en high.
- R9: With flt_en low, flt_sel and flt_val have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | M*M | Data word, bit r*M+j sits in grid row r, column j |
| flt_en | input | 1 | Enables the single-node override |
| flt_sel | input | clog2(2M(M-1)+1) | Index of the gate output to override |
| flt_val | input | 1 | Value forced onto the selected gate output |
| check_out | output | 2M | Row checks in the low M bits, column checks in the high M bits |
| rail_a | output | 1 | Parity of the row checks |
| rail_b | output | 1 | Parity of the column checks |
| enc_err | output | 1 | Rails disagree: internal fault detected |

## Verification
The bench builds the encoder with the default M = 4. At that size the 16-bit data space is small enough to drive every data word fault-free, which covers R1, R2, R4 and R5 completely rather than by sampling. At the same size all 24 gate outputs, plus the eight out-of-range selector codes, can be forced to both values over several data words. Each forced case is predicted from the gate's fault-free partial parity, so both the masked and the detected outcomes of a stuck node are checked.

// File: rtl/ols_sc_encoder.sv
module ols_sc_encoder #(
  parameter int M = 4,
  localparam int K = M * M,
  localparam int NC = 2 * M,
  localparam int GPC = M - 1,
  localparam int NN = NC * GPC,
  localparam int SW = $clog2(NN + 1)
) (
  input  logic [K-1:0]  data_in,
  input  logic          flt_en,
  input  logic [SW-1:0] flt_sel,
  input  logic          flt_val,
  output logic [NC-1:0] check_out,
  output logic          rail_a,
  output logic          rail_b,
  output logic          enc_err
);

  logic [NN-1:0] nd;

  for (genvar c = 0; c < NC; c++) begin : g_chk
    localparam int BASE = (c < M) ? c * M : c - M;
    localparam int STEP = (c < M) ? 1 : M;
    for (genvar g = 0; g < GPC; g++) begin : g_gate
      localparam int IDX = c * GPC + g;
      logic lhs, raw;
      if (g == 0) begin : g_first
        assign lhs = data_in[BASE];
      end else begin : g_next
        assign lhs = nd[IDX-1];
      end
      assign raw = lhs ^ data_in[BASE + (g + 1) * STEP];
      assign nd[IDX] = (flt_en && flt_sel == SW'(IDX)) ? flt_val : raw;
    end
    assign check_out[c] = nd[c * GPC + GPC - 1];
  end

  assign rail_a  = ^check_out[M-1:0];
  assign rail_b  = ^check_out[NC-1:M];
  assign enc_err = rail_a ^ rail_b;

endmodule

// File: rtl/ols_sc_encoder_chk.sv
module ols_sc_encoder_chk #(
  parameter int M = 4,
  localparam int K = M * M,
  localparam int NC = 2 * M,
  localparam int NN = NC * (M - 1),
  localparam int SW = $clog2(NN + 1)
) (
  input logic [K-1:0]  data_in,
  input logic          flt_en,
  input logic [SW-1:0] flt_sel,
  input logic          flt_val,
  input logic [NC-1:0] check_out,
  input logic          rail_a,
  input logic          rail_b,
  input logic          enc_err
);

  function automatic logic [NC-1:0] grid_parity(input logic [K-1:0] d);
    logic [NC-1:0] p;
    p = '0;
    for (int r = 0; r < M; r++)
      for (int j = 0; j < M; j++) begin
        p[r]     = p[r] ^ d[r*M + j];
        p[M + j] = p[M + j] ^ d[r*M + j];
      end
    return p;
  endfunction

  always_comb begin
    logic [NC-1:0] expv;
    expv = grid_parity(data_in);
    // R4
    no_fault_clean_chk: assert (flt_en || (!enc_err && rail_a == rail_b));
    // R1
    ref_match_chk: assert (flt_en || check_out == expv);
    // R5
    err_matches_parity_chk: assert (enc_err == ^check_out);
    // R6
    single_bit_dev_chk: assert ($countones(check_out ^ expv) <= 1);
    // R8
    bad_sel_inert_chk: assert (int'(flt_sel) < NN || check_out == expv);
  end

endmodule

bind ols_sc_encoder ols_sc_encoder_chk #(.M(M)) u_chk (.*);

// File: tb/ols_sc_encoder_test.sv
module ols_sc_encoder_test;
  localparam int M = 4;
  localparam int K = M * M;
  localparam int NC = 2 * M;
  localparam int GPC = M - 1;
  localparam int NN = NC * GPC;
  localparam int SW = $clog2(NN + 1);

  typedef struct {
    logic [NC-1:0] chk;
    logic          ra;
    logic          rb;
    logic          err;
    string         tag;
  } item_t;

  logic clk = 0;
  logic rst_n = 0;
  logic [K-1:0] data_in = '0;
  logic flt_en = 0;
  logic [SW-1:0] flt_sel = '0;
  logic flt_val = 0;
  logic [NC-1:0] check_out;
  logic rail_a, rail_b, enc_err;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  item_t sb[$];

  ols_sc_encoder uut (.*);

  always #4 clk = ~clk;

  function automatic logic member(input logic [K-1:0] d, input int c, input int i);
    return (c < M) ? d[c*M + i] : d[(c-M) + i*M];
  endfunction

  function automatic logic partial(input logic [K-1:0] d, input int c, input int g);
    logic v;
    v = member(d, c, 0);
    for (int i = 1; i <= g + 1; i++) v ^= member(d, c, i);
    return v;
  endfunction

  task automatic check_item(input string tag, input bit ok, input string what,
                            input logic [NC-1:0] act, input logic [NC-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [K-1:0] d, input logic en, input int sel,
                       input logic val, input string tag);
    item_t it;
    @(posedge clk);
    data_in = d; flt_en = en; flt_sel = SW'(sel); flt_val = val;
    for (int c = 0; c < NC; c++) it.chk[c] = partial(d, c, GPC - 1);
    if (en && sel < NN) begin
      if (partial(d, sel / GPC, sel % GPC) != val) it.chk[sel / GPC] ^= 1'b1;
    end
    it.ra = ^it.chk[M-1:0];
    it.rb = ^it.chk[NC-1:M];
    it.err = it.ra ^ it.rb;
    it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check_item(it.tag, check_out === it.chk, "check_out", check_out, it.chk);
        check_item(it.tag, {rail_a, rail_b} === {it.ra, it.rb}, "rails",
                   NC'({rail_a, rail_b}), NC'({it.ra, it.rb}));
        check_item(it.tag, enc_err === it.err, "enc_err", NC'(enc_err), NC'(it.err));
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    rst_n = 1;
    #1;
    checks++;
    if (check_out !== '0 || enc_err !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle actual=%h expected=0", check_out);
    end
    // R3 walking single bits: two checks each, one row and one column
    for (int b = 0; b < K; b++) begin
      logic [NC-1:0] e;
      e = '0; e[b / M] = 1'b1; e[M + b % M] = 1'b1;
      drive(K'(1) << b, 1'b0, 0, 1'b0, "R3");
      checks++;
      if ($countones(e) != 2) begin
        fails++;
        $display("FAIL R3 weight actual=%0d expected=2", $countones(e));
      end
    end
    // R1 R2 R4 R5 every data word, no fault
    for (int v = 0; v < (1 << K); v++) drive(K'(v), 1'b0, 0, 1'b0, "R1_R2_R4_R5");
    // R9 override disabled but selector and value toggled
    for (int s = 0; s < 32; s++) drive(K'(16'hA5C3 + s * 977), 1'b0, s, s[0], "R9");
    // R6 R7 each node forced to both values over several words
    for (int n = 0; n < NN; n++)
      for (int v = 0; v < 2; v++) begin
        drive(16'h0000, 1'b1, n, v[0], "R6_R7");
        drive(16'hFFFF, 1'b1, n, v[0], "R6_R7");
        drive(16'h1E6B, 1'b1, n, v[0], "R6_R7");
        drive(K'($urandom), 1'b1, n, v[0], "R6_R7");
      end
    // R8 out-of-range selectors
    for (int n = NN; n < (1 << SW); n++)
      for (int v = 0; v < 2; v++) drive(K'(16'h3C96 ^ n), 1'b1, n, v[0], "R8");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule